// File: doc/BRIEF.md
# Fast-Interrupt Status Register

This block assembles a 32-bit read-only interrupt status word for sixteen interrupt sources. It also generates three fast-interrupt sources itself:

- an external fast-interrupt pin, reported at its live level;
- a battery-low detector that filters its condition over a slow sample enable;
- a tick watchdog that fires when the periodic tick interrupt is still pending at the next tick.

The remaining thirteen sources are raw lines from peripherals, copied into the word unchanged. The three fast sources are merged into one registered fast-interrupt request for the processor.

Software reads `status_o`. It acknowledges the battery-low and watchdog flags by pulsing the matching clear strobe. While the system is in standby, the battery-low and watchdog logic are both held idle. All pins are plain level or single-cycle pulse signals: no data stream passes through the block, so it has no valid/ready handshake.

Top module: `irq_status_core`

## Requirements
- R1: `status_o[31:16]` reads as zero at all times.
- R2: `status_o[0]` is the inverse of `ext_fiq_n_i`, in the same cycle, with no latching.
- R3: `status_o[15:3]` equals `periph_irq_i[12:0]` in the same cycle. Line k appears at bit k+3, and the tick-interrupt pending line is `periph_irq_i[8]` (status bit 11).
- R4: The battery-low condition is true only when `ext_pwr_n_i` is 1 and `batt_ok_i` is 0. Any other pin combination never raises `status_o[1]`.
- R5: On every cycle with `smp_en_i` high, a true condition adds one to a run count and a false condition zeroes it. `status_o[1]` goes to 1 in the cycle after the third consecutive true sample.
- R6: Once set, `status_o[1]` holds until a `batt_clr_i` pulse clears it. If the condition is still true after the clear, the next true sample sets it again.
- R7: A `tick_en_i` pulse while `periph_irq_i[8]` is 1 sets `status_o[2]` in the next cycle. The flag holds until a `tick_clr_i` pulse. A tick with the pending line low does nothing.
- R8: When a set event and a clear strobe for the same flag fall in the same cycle, the flag ends up set.
- R9: While `standby_i` is high:
  - bits 2:1 read zero from the next cycle on;
  - the run count is zeroed;
  - sample and tick pulses have no effect.
  
  After standby ends, three new true samples are needed to set the battery-low flag.
- R10: `fiq_o` equals the OR of `status_o[2:0]` delayed by one clock.
- R11: During reset, and after it, bits 2:1 and `fiq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_fiq_n_i | input | 1 | External fast-interrupt pin, active low |
| ext_pwr_n_i | input | 1 | External supply present, active low |
| batt_ok_i | input | 1 | Battery OK pin, high when healthy |
| smp_en_i | input | 1 | One-cycle pulse at the slow (16 kHz) sample rate |
| tick_en_i | input | 1 | One-cycle pulse at each tick edge (64 Hz) |
| standby_i | input | 1 | Standby state indication |
| batt_clr_i | input | 1 | Battery-low clear strobe |
| tick_clr_i | input | 1 | Tick end-of-interrupt strobe, clears the watchdog flag |
| periph_irq_i | input | 13 | Raw peripheral interrupt lines for status bits 15:3 |
| status_o | output | 32 | Interrupt status word |
| fiq_o | output | 1 | Registered fast-interrupt request |

## Verification
A run count stuck at the wrong value shows at the port as a change in timing. `status_o[1]` rises one sample too early or too late, or, if a false sample fails to zero the count, rises after a broken run. This is visible within three sample pulses of the fault. A flag with the wrong hold or priority behaviour shows on the first clear strobe, on the cycle that follows. Because `fiq_o` lags the status bits by exactly one clock, a missing or extra register stage appears on the first edge of any fast source.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int STATUS_W     = 32;
  localparam int NUM_SRC      = 16;
  localparam int IDX_EXT      = 0;
  localparam int IDX_BATT     = 1;
  localparam int IDX_WDOG     = 2;
  localparam int IDX_PERIPH   = 3;
  localparam int IDX_TICK     = 11;
  localparam int NUM_PERIPH   = NUM_SRC - IDX_PERIPH;
  localparam int TICK_LINE    = IDX_TICK - IDX_PERIPH;

  typedef struct packed {
    logic wdog;
    logic batt;
    logic ext;
  } fast_src_t;
endpackage

// File: rtl/batt_deglitch.sv
module batt_deglitch #(
  parameter int SMP_THRESH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_pwr_n_i,
  input  logic batt_ok_i,
  input  logic smp_en_i,
  input  logic standby_i,
  input  logic clr_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(SMP_THRESH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(SMP_THRESH);
  localparam logic [CNT_W-1:0] CNT_ARM  = CNT_W'(SMP_THRESH - 1);

  logic             cond;
  logic             set_ev;
  logic [CNT_W-1:0] run_q;
  logic             flag_q;

  assign cond   = ext_pwr_n_i & ~batt_ok_i;
  assign set_ev = smp_en_i & cond & (run_q >= CNT_ARM) & ~standby_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else if (standby_i) begin
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (smp_en_i) begin
        if (!cond)                run_q <= '0;
        else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
      end
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  assert_standby_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (run_q == '0) && !flag_q);

  assert_false_sample_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en_i && !cond && !standby_i) |=> (run_q == '0));

  assert_hold_until_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i && !standby_i) |=> flag_q);

  assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en_i && cond && clr_i && !standby_i && run_q >= CNT_ARM) |=> flag_q);

  assert_no_rise_without_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !smp_en_i) |=> !flag_q);
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  input  logic tick_pend_i,
  input  logic standby_i,
  input  logic clr_i,
  output logic flag_o
);
  logic expire;
  logic flag_q;

  assign expire = tick_en_i & tick_pend_i & ~standby_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (standby_i)  flag_q <= 1'b0;
    else if (expire)     flag_q <= 1'b1;
    else if (clr_i)      flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  assert_expiry_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en_i && tick_pend_i && !standby_i) |=> flag_q);

  assert_rise_needs_pending_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !(tick_en_i && tick_pend_i)) |=> !flag_q);

  assert_standby_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !flag_q);
endmodule

// File: rtl/status_assemble.sv
module status_assemble
  import irq_status_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  fast_src_t             fast_i,
  input  logic [NUM_PERIPH-1:0] periph_i,
  output logic [STATUS_W-1:0]   status_o,
  output logic                  fiq_o
);
  logic [STATUS_W-1:0] word;
  logic                fiq_q;

  always_comb begin
    word            = '0;
    word[IDX_EXT]   = fast_i.ext;
    word[IDX_BATT]  = fast_i.batt;
    word[IDX_WDOG]  = fast_i.wdog;
  end

  genvar g;
  for (g = 0; g < NUM_PERIPH; g++) begin : g_periph
    assign status_o[IDX_PERIPH + g] = periph_i[g];
  end
  assign status_o[IDX_PERIPH-1:0]        = word[IDX_PERIPH-1:0];
  assign status_o[STATUS_W-1:NUM_SRC]    = word[STATUS_W-1:NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fiq_q <= 1'b0;
    else        fiq_q <= |fast_i;
  end
  assign fiq_o = fiq_q;

  assert_fiq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_o[IDX_WDOG:IDX_EXT]) |=> fiq_o);

  assert_fiq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|status_o[IDX_WDOG:IDX_EXT]) |=> !fiq_o);
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
  import irq_status_pkg::*;
#(
  parameter int SMP_THRESH = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_fiq_n_i,
  input  logic                  ext_pwr_n_i,
  input  logic                  batt_ok_i,
  input  logic                  smp_en_i,
  input  logic                  tick_en_i,
  input  logic                  standby_i,
  input  logic                  batt_clr_i,
  input  logic                  tick_clr_i,
  input  logic [12:0]           periph_irq_i,
  output logic [31:0]           status_o,
  output logic                  fiq_o
);
  fast_src_t fast;
  logic      batt_flag;
  logic      wdog_flag;

  batt_deglitch #(.SMP_THRESH(SMP_THRESH)) u_batt (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_pwr_n_i (ext_pwr_n_i),
    .batt_ok_i   (batt_ok_i),
    .smp_en_i    (smp_en_i),
    .standby_i   (standby_i),
    .clr_i       (batt_clr_i),
    .flag_o      (batt_flag)
  );

  tick_watchdog u_wdog (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en_i   (tick_en_i),
    .tick_pend_i (periph_irq_i[TICK_LINE]),
    .standby_i   (standby_i),
    .clr_i       (tick_clr_i),
    .flag_o      (wdog_flag)
  );

  assign fast.ext  = ~ext_fiq_n_i;
  assign fast.batt = batt_flag;
  assign fast.wdog = wdog_flag;

  status_assemble u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_i   (fast),
    .periph_i (periph_irq_i),
    .status_o (status_o),
    .fiq_o    (fiq_o)
  );

  assert_ext_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[IDX_EXT] == !ext_fiq_n_i);

  assert_reserved_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[31:16] == 16'h0);

  assert_batt_needs_condition_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o[IDX_BATT] && !(ext_pwr_n_i && !batt_ok_i)) |=> !status_o[IDX_BATT]);
endmodule

// File: tb/test_irq_status_core.sv
`timescale 1ns/1ps
module test_irq_status_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_fiq_n = 1'b1, ext_pwr_n = 1'b0, batt_ok = 1'b1;
  logic        smp_en = 1'b0, tick_en = 1'b0, standby = 1'b0;
  logic        batt_clr = 1'b0, tick_clr = 1'b0;
  logic [12:0] periph = '0;
  logic [31:0] status;
  logic        fiq;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_status_core i_irq_status_core (
    .clk(clk), .rst_n(rst_n), .ext_fiq_n_i(ext_fiq_n), .ext_pwr_n_i(ext_pwr_n),
    .batt_ok_i(batt_ok), .smp_en_i(smp_en), .tick_en_i(tick_en), .standby_i(standby),
    .batt_clr_i(batt_clr), .tick_clr_i(tick_clr), .periph_irq_i(periph),
    .status_o(status), .fiq_o(fiq)
  );

  // {ext_fiq_n, periph[12:0], expected status[15:0]}
  localparam logic [29:0] VEC [7] = '{
    {1'b1, 13'h0000, 16'h0000},
    {1'b0, 13'h0000, 16'h0001},
    {1'b1, 13'h0001, 16'h0008},
    {1'b1, 13'h1000, 16'h8000},
    {1'b0, 13'h1555, 16'hAAA9},
    {1'b1, 13'h0AAA, 16'h5550},
    {1'b1, 13'h0100, 16'h0800}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic smp();
    smp_en = 1'b1; step(); smp_en = 1'b0;
  endtask

  task automatic tick();
    tick_en = 1'b1; step(); tick_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(); step();
    chk("R11 reset status", status, 32'h0);
    chk("R11 reset fiq", {31'h0, fiq}, 32'h0);
    rst_n = 1'b1; step();

    // R1 R2 R3 table walk
    for (int i = 0; i < 7; i++) begin
      ext_fiq_n = VEC[i][29];
      periph    = VEC[i][28:16];
      step();
      chk("R2/R3 low half", {16'h0, status[15:0]}, {16'h0, VEC[i][15:0]});
      chk("R1 reserved", {16'h0, status[31:16]}, 32'h0);
    end
    ext_fiq_n = 1'b1; periph = '0; step(); step();

    // R5 deglitch run
    ext_pwr_n = 1'b1; batt_ok = 1'b0;
    smp(); smp();
    chk("R5 two samples", {31'h0, status[1]}, 32'h0);
    batt_ok = 1'b1; smp(); batt_ok = 1'b0;
    smp(); smp();
    chk("R5 broken run", {31'h0, status[1]}, 32'h0);
    smp();
    chk("R5 third sample", {31'h0, status[1]}, 32'h1);
    chk("R10 fiq lags", {31'h0, fiq}, 32'h0);
    step();
    chk("R10 fiq follows", {31'h0, fiq}, 32'h1);

    // R6 hold and clear
    batt_ok = 1'b1; smp(); smp();
    chk("R6 hold", {31'h0, status[1]}, 32'h1);
    batt_clr = 1'b1; step(); batt_clr = 1'b0;
    chk("R6 clear", {31'h0, status[1]}, 32'h0);
    step();
    chk("R10 fiq drops", {31'h0, fiq}, 32'h0);
    batt_ok = 1'b0; smp(); smp(); smp();
    batt_clr = 1'b1; step(); batt_clr = 1'b0;
    chk("R6 clear persisting", {31'h0, status[1]}, 32'h0);
    smp();
    chk("R6 re-raise", {31'h0, status[1]}, 32'h1);

    // R8 set beats clear
    batt_clr = 1'b1; smp(); batt_clr = 1'b0;
    chk("R8 batt set wins", {31'h0, status[1]}, 32'h1);
    batt_clr = 1'b1; step(); batt_clr = 1'b0;
    chk("R8 batt then cleared", {31'h0, status[1]}, 32'h0);

    // R4 condition combinations
    ext_pwr_n = 1'b0; batt_ok = 1'b0;
    repeat (4) smp();
    chk("R4 powered", {31'h0, status[1]}, 32'h0);
    ext_pwr_n = 1'b1; batt_ok = 1'b1;
    repeat (4) smp();
    chk("R4 battery ok", {31'h0, status[1]}, 32'h0);

    // R7 watchdog
    tick();
    chk("R7 no pending", {31'h0, status[2]}, 32'h0);
    periph[8] = 1'b1; tick(); periph[8] = 1'b0;
    chk("R7 expiry", {31'h0, status[2]}, 32'h1);
    step(); step();
    chk("R7 hold", {31'h0, status[2]}, 32'h1);
    tick_clr = 1'b1; step(); tick_clr = 1'b0;
    chk("R7 clear", {31'h0, status[2]}, 32'h0);
    periph[8] = 1'b1; tick_clr = 1'b1; tick(); tick_clr = 1'b0;
    chk("R8 wdog set wins", {31'h0, status[2]}, 32'h1);
    step();
    chk("R10 fiq wdog", {31'h0, fiq}, 32'h1);

    // R9 standby
    batt_ok = 1'b0; smp(); smp(); smp();
    chk("R9 pre standby", {30'h0, status[2:1]}, 32'h3);
    standby = 1'b1; step();
    chk("R9 standby clears", {30'h0, status[2:1]}, 32'h0);
    repeat (4) smp();
    tick();
    chk("R9 ignored in standby", {30'h0, status[2:1]}, 32'h0);
    chk("R9 fiq quiet", {31'h0, fiq}, 32'h0);
    periph[8] = 1'b0; standby = 1'b0;
    smp(); smp();
    chk("R9 count restarted", {31'h0, status[1]}, 32'h0);
    smp();
    chk("R9 rise after exit", {31'h0, status[1]}, 32'h1);

    // R2 ext pin into fiq, R11 reset mid-run
    batt_ok = 1'b1; batt_clr = 1'b1; step(); batt_clr = 1'b0; step();
    ext_fiq_n = 1'b0; #1;
    chk("R2 immediate", {31'h0, status[0]}, 32'h1);
    step();
    chk("R10 fiq ext", {31'h0, fiq}, 32'h1);
    ext_fiq_n = 1'b1;
    batt_ok = 1'b0; smp(); smp(); smp();
    rst_n = 1'b0; #1;
    chk("R11 async reset", {29'h0, status[2:0], fiq}, 32'h0);
    step(); rst_n = 1'b1; step();
    chk("R11 after reset", {30'h0, status[2:1]}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule